// File: doc/BRIEF.md
# Timed-Edge Encoded D Flip-Flop

This block is a single-bit D flip-flop for a design in which each fast signal travels as one start level plus a short list of offset-tagged transitions per reference clock cycle. The offsets quantise one reference period into `2**OFS_W` steps. The clock and data inputs each arrive in this form. In the same reference cycle, the flop works out where the clock rises and what the data level is at that point. It then reports an output transition, tagged with the clock edge's offset, whenever the stored value changes.

All evaluation inside a reference cycle is combinational. The only register is a loop-break register. It carries the output's final level into the next reference cycle, where that level becomes the output's start level. This breaks the feedback that would otherwise hold the state through a combinational loop.

Clock transition slots may arrive in any order. The block ranks them by offset, with ties going to the lower slot index. Only the first two clock edges of a cycle are evaluated. A third or later edge raises an overflow flag and is ignored.

The evaluation of each kept clock edge is expressed as an edge kind:
- `EDGE_NONE`: the slot holds no kept edge.
- `EDGE_RISE`: the edge samples data.
- `EDGE_FALL`: the edge has no effect.

The kind is reached by one of two transitions of the clock level. With a start level of 0, the first edge is `EDGE_RISE` and the second is `EDGE_FALL`. With a start level of 1, the order is reversed.

Top module: `tdff_timed`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `q_start_o` is 0. With no clock edges, no output transition is reported.
- R2: When a kept rising clock edge samples a data level different from the current state, `q_tr_vld_o` is 1 and `q_tr_ofs_o` equals that edge's offset.
- R3: The data level sampled at offset t equals `d_start_i`, toggled once for each valid data slot i whose offset `d_ofs_i[i*OFS_W +: OFS_W]` is less than or equal to t.
- R4: Falling clock edges have no effect. A rising edge whose sampled level equals the state reports no transition. `q_start_o` is unchanged in the next cycle whenever no transition was reported.
- R5: The loop-break register loads `q_end_o`, the output level after the last kept edge, so next cycle's `q_start_o` equals this cycle's `q_end_o`.
- R6: Clock slots are unordered. Kept edges are processed in ascending offset order, and ties are broken by the lower slot index.
- R7: With more than two valid clock slots, `ck_over_o` is 1 in the same cycle. Only the two earliest edges, in the R6 order, are evaluated.
- R8: Each valid clock slot toggles the clock level. The first kept edge is rising when `ck_start_i` is 0, and the second kept edge is rising when `ck_start_i` is 1.
- R9: `q_tr_vld_o`, `q_tr_ofs_o`, `q_end_o` and `ck_over_o` respond to the inputs in the same reference cycle, without a register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ck_start_i | input | 1 | Timed clock level at the start of the cycle |
| ck_vld_i | input | CLK_SLOTS | Valid flag for each clock transition slot |
| ck_ofs_i | input | CLK_SLOTS*OFS_W | Offset of each clock transition slot |
| d_start_i | input | 1 | Timed data level at the start of the cycle |
| d_vld_i | input | DAT_SLOTS | Valid flag for each data transition slot |
| d_ofs_i | input | DAT_SLOTS*OFS_W | Offset of each data transition slot |
| q_start_o | output | 1 | Output start level (loop-break register) |
| q_tr_vld_o | output | 1 | An output transition occurs this cycle |
| q_tr_ofs_o | output | OFS_W | Offset of the output transition |
| q_end_o | output | 1 | Output level at the end of the cycle |
| ck_over_o | output | 1 | More than two clock edges were presented |

## Verification
The bench builds the block with its default parameters: OFS_W=3, giving eight offsets, and four transition slots each for clock and data. Eight offsets are few enough to sweep every pair of clock edge positions against every single data transition position, for both start levels. That sweep reaches every tie and every ordering of sampling around a clock edge. Random vectors that fill all four slots of each input then cover the overflow path and unordered slots, with the state carried across cycles.

// File: rtl/tdff_pkg.sv
package tdff_pkg;
    localparam int EDGE_LIMIT = 2;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } edge_kind_t;
endpackage

// File: rtl/tdff_level_at.sv
module tdff_level_at #(
    parameter int NSLOT = 4,
    parameter int OFS_W = 3
) (
    input  logic                   start_lvl,
    input  logic [NSLOT-1:0]       vld,
    input  logic [NSLOT*OFS_W-1:0] ofs,
    input  logic [OFS_W-1:0]       at_ofs,
    output logic                   lvl_o
);
    // Level at at_ofs: start level toggled by every transition not later than it.
    always_comb begin
        lvl_o = start_lvl;
        for (int i = 0; i < NSLOT; i++) begin
            if (vld[i] && (ofs[i*OFS_W +: OFS_W] <= at_ofs)) begin
                lvl_o = ~lvl_o;
            end
        end
    end
endmodule

// File: rtl/tdff_edge_pick.sv
module tdff_edge_pick
    import tdff_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int OFS_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_lvl,
    input  logic [NSLOT-1:0]       vld,
    input  logic [NSLOT*OFS_W-1:0] ofs,
    output edge_kind_t             kind_o [EDGE_LIMIT],
    output logic [OFS_W-1:0]       ofs_o  [EDGE_LIMIT],
    output logic                   over_o
);
    localparam int CNT_W = $clog2(NSLOT + 1);

    logic [CNT_W-1:0] rank  [NSLOT];
    logic [CNT_W-1:0] total;

    // Rank of each valid slot: earlier offsets first, lower index wins ties.
    always_comb begin
        total = '0;
        for (int i = 0; i < NSLOT; i++) begin
            rank[i] = '0;
            if (vld[i]) total = total + 1'b1;
            for (int j = 0; j < NSLOT; j++) begin
                if (vld[j] && (j != i) &&
                    ((ofs[j*OFS_W +: OFS_W] < ofs[i*OFS_W +: OFS_W]) ||
                     ((ofs[j*OFS_W +: OFS_W] == ofs[i*OFS_W +: OFS_W]) && (j < i)))) begin
                    rank[i] = rank[i] + 1'b1;
                end
            end
        end
    end

    assign over_o = (total > CNT_W'(EDGE_LIMIT));

    // Kept edge k leaves the clock at start ^ (k even); a 1 there is a rise.
    always_comb begin
        for (int k = 0; k < EDGE_LIMIT; k++) begin
            kind_o[k] = EDGE_NONE;
            ofs_o[k]  = '0;
            for (int i = 0; i < NSLOT; i++) begin
                if (vld[i] && (rank[i] == CNT_W'(k))) begin
                    kind_o[k] = ((start_lvl ^ ((k % 2) == 0)) == 1'b1) ? EDGE_RISE : EDGE_FALL;
                    ofs_o[k]  = ofs[i*OFS_W +: OFS_W];
                end
            end
        end
    end

    p_kept_in_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o[1] != EDGE_NONE) |-> ((kind_o[0] != EDGE_NONE) && (ofs_o[0] <= ofs_o[1])));

    p_edges_alternate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o[1] != EDGE_NONE) |-> (kind_o[0] != kind_o[1]));

    p_over_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        over_o |-> ((kind_o[0] != EDGE_NONE) && (kind_o[1] != EDGE_NONE)));
endmodule

// File: rtl/tdff_timed.sv
module tdff_timed
    import tdff_pkg::*;
#(
    parameter int OFS_W     = 3,
    parameter int CLK_SLOTS = 4,
    parameter int DAT_SLOTS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ck_start_i,
    input  logic [CLK_SLOTS-1:0]       ck_vld_i,
    input  logic [CLK_SLOTS*OFS_W-1:0] ck_ofs_i,
    input  logic                       d_start_i,
    input  logic [DAT_SLOTS-1:0]       d_vld_i,
    input  logic [DAT_SLOTS*OFS_W-1:0] d_ofs_i,
    output logic                       q_start_o,
    output logic                       q_tr_vld_o,
    output logic [OFS_W-1:0]           q_tr_ofs_o,
    output logic                       q_end_o,
    output logic                       ck_over_o
);
    edge_kind_t       kind  [EDGE_LIMIT];
    logic [OFS_W-1:0] e_ofs [EDGE_LIMIT];
    logic             samp  [EDGE_LIMIT];
    logic             state_q;

    tdff_edge_pick #(.NSLOT(CLK_SLOTS), .OFS_W(OFS_W)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_lvl (ck_start_i),
        .vld       (ck_vld_i),
        .ofs       (ck_ofs_i),
        .kind_o    (kind),
        .ofs_o     (e_ofs),
        .over_o    (ck_over_o)
    );

    for (genvar k = 0; k < EDGE_LIMIT; k++) begin : g_samp
        tdff_level_at #(.NSLOT(DAT_SLOTS), .OFS_W(OFS_W)) u_lvl (
            .start_lvl (d_start_i),
            .vld       (d_vld_i),
            .ofs       (d_ofs_i),
            .at_ofs    (e_ofs[k]),
            .lvl_o     (samp[k])
        );
    end

    // Loop-break register: end-of-cycle level becomes next start level.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= 1'b0;
        else        state_q <= q_end_o;
    end

    assign q_start_o = state_q;

    // Walk the kept edges in order within the cycle.
    always_comb begin
        q_end_o    = state_q;
        q_tr_vld_o = 1'b0;
        q_tr_ofs_o = '0;
        for (int k = 0; k < EDGE_LIMIT; k++) begin
            unique case (kind[k])
                EDGE_RISE: begin
                    if (samp[k] != q_end_o) begin
                        q_end_o    = samp[k];
                        q_tr_vld_o = 1'b1;
                        q_tr_ofs_o = e_ofs[k];
                    end
                end
                EDGE_FALL, EDGE_NONE: ;
                default: ;
            endcase
        end
    end

    p_tr_flips_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q_tr_vld_o |=> (q_start_o != $past(q_start_o)));

    p_hold_without_tr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !q_tr_vld_o |=> $stable(q_start_o));

    p_tr_at_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q_tr_vld_o |-> (((kind[0] == EDGE_RISE) && (e_ofs[0] == q_tr_ofs_o)) ||
                        ((kind[1] == EDGE_RISE) && (e_ofs[1] == q_tr_ofs_o))));

    p_single_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({kind[0] == EDGE_RISE, kind[1] == EDGE_RISE}));
endmodule

// File: tb/tdff_timed_tb.sv
`timescale 1ns/1ps
module tdff_timed_tb;
    localparam int OW = 3;
    localparam int NC = 4;
    localparam int ND = 4;
    localparam int NOFS = 1 << OW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n;
    logic             ck_start, d_start;
    logic [NC-1:0]    ck_vld;
    logic [NC*OW-1:0] ck_ofs;
    logic [ND-1:0]    d_vld;
    logic [ND*OW-1:0] d_ofs;
    logic             q_start, q_tr_vld, q_end, ck_over;
    logic [OW-1:0]    q_tr_ofs;

    int    n_vec = 0;
    int    n_bad = 0;
    logic  m_state;
    bit    done = 0;
    logic [31:0] lcg = 32'h1234_5678;

    tdff_timed #(.OFS_W(OW), .CLK_SLOTS(NC), .DAT_SLOTS(ND)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ck_start_i(ck_start), .ck_vld_i(ck_vld), .ck_ofs_i(ck_ofs),
        .d_start_i(d_start), .d_vld_i(d_vld), .d_ofs_i(d_ofs),
        .q_start_o(q_start), .q_tr_vld_o(q_tr_vld), .q_tr_ofs_o(q_tr_ofs),
        .q_end_o(q_end), .ck_over_o(ck_over)
    );

    function automatic logic dlev(input logic s, input logic [ND-1:0] v,
                                  input logic [ND*OW-1:0] o, input int at);
        logic l = s;
        for (int i = 0; i < ND; i++)
            if (v[i] && (int'(o[i*OW +: OW]) <= at)) l = ~l;
        return l;
    endfunction

    task automatic apply(input string tag, input logic cs, input logic [NC-1:0] cv,
                         input logic [NC*OW-1:0] co, input logic ds,
                         input logic [ND-1:0] dv, input logic [ND*OW-1:0] dof);
        int   cnt = 0;
        logic lvl = cs;
        logic st  = m_state;
        logic ev  = 1'b0;
        int   eo  = 0;
        bit   bad = 0;
        @(negedge clk);
        ck_start = cs; ck_vld = cv; ck_ofs = co;
        d_start = ds; d_vld = dv; d_ofs = dof;
        #1;
        // Reference: scan offsets in time order, slots by index (R6); cap at two edges (R7).
        for (int o = 0; o < NOFS; o++) begin
            for (int i = 0; i < NC; i++) begin
                if (cv[i] && (int'(co[i*OW +: OW]) == o)) begin
                    if (cnt < 2) begin
                        lvl = ~lvl;                                  // R8 toggle
                        if (lvl && (dlev(ds, dv, dof, o) != st)) begin // R3 sample
                            st = ~st; ev = 1'b1; eo = o;
                        end
                    end
                    cnt++;
                end
            end
        end
        n_vec++;
        if (q_start !== m_state) begin
            bad = 1; $display("FAIL %s R5 q_start act=%0b exp=%0b", tag, q_start, m_state);
        end
        if (q_tr_vld !== ev) begin
            bad = 1; $display("FAIL %s R2/R4 tr_vld act=%0b exp=%0b", tag, q_tr_vld, ev);
        end
        if (ev && (int'(q_tr_ofs) != eo)) begin
            bad = 1; $display("FAIL %s R2 tr_ofs act=%0d exp=%0d", tag, q_tr_ofs, eo);
        end
        if (q_end !== st) begin
            bad = 1; $display("FAIL %s R3 q_end act=%0b exp=%0b", tag, q_end, st);
        end
        if (ck_over !== (cnt > 2)) begin
            bad = 1; $display("FAIL %s R7 ck_over act=%0b exp=%0b", tag, ck_over, cnt > 2);
        end
        if (bad) n_bad++;
        m_state = st;
    endtask

    function automatic logic [31:0] step(input logic [31:0] x);
        return x * 32'd1664525 + 32'd1013904223;
    endfunction

    initial begin
        rst_n = 1'b0; ck_start = 0; ck_vld = '0; ck_ofs = '0;
        d_start = 0; d_vld = '0; d_ofs = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (q_start !== 1'b0) begin
            n_bad++; $display("FAIL R1 reset q_start act=%0b exp=0", q_start);
        end
        rst_n = 1'b1;
        m_state = 1'b0;
        apply("R1 idle", 0, 4'b0000, '0, 1, 4'b0000, '0);
        // R8: start high, lone edge falls: nothing happens (R4)
        apply("R8 fall", 1, 4'b0001, 12'(3), 1, 4'b0000, '0);
        // R6: unordered slots, rise at 2 (slot1), fall at 5 (slot0)
        apply("R6 order", 0, 4'b0011, {6'd0, 3'd2, 3'd5}, 1, 4'b0000, '0);
        // R3: data transition at the same offset as the rise is seen
        apply("R3 equal", 0, 4'b0001, 12'(4), 1, 4'b0001, 12'(4));
        // R4: same level again, no transition; R9 same-cycle outputs throughout
        apply("R4 same", 0, 4'b0001, 12'(1), 0, 4'b0000, '0);
        // R7: four edges, only rise@1 fall@2 count; rise@3 ignored
        apply("R7 over", 0, 4'b1111, {3'd6, 3'd3, 3'd2, 3'd1}, 1, 4'b0001, 12'(2));
        // Sweep: two clock edges x one data transition, both start levels
        for (int cs = 0; cs < 2; cs++)
            for (int a = 0; a < NOFS; a++)
                for (int b = 0; b < NOFS; b++)
                    for (int c = 0; c < NOFS; c++)
                        for (int ds = 0; ds < 2; ds++)
                            apply("sweep", cs[0], 4'b0011, {6'd0, 3'(b), 3'(a)},
                                  ds[0], 4'b0001, 12'(c));
        // Random full-slot vectors (R6, R7)
        for (int n = 0; n < 6000; n++) begin
            logic [NC-1:0] cv; logic [NC*OW-1:0] co;
            logic [ND-1:0] dv; logic [ND*OW-1:0] dof;
            logic cs, ds;
            lcg = step(lcg); cv = lcg[27:24]; co = lcg[11:0]; cs = lcg[30];
            lcg = step(lcg); dv = lcg[27:24]; dof = lcg[11:0]; ds = lcg[30];
            apply("random", cs, cv, co, ds, dv, dof);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule